// File: doc/BRIEF.md
# Two-Wire Bus Control Pattern Detector

The block watches two serial lines, A and B, that are sampled by a much faster system clock. Both lines pass through two-flop synchronisers. The detector arms when line A is low and line B is high. While armed, it counts the falling edges of line B. The window closes on the first rising edge of line A. At that moment the detector classifies the window from two things: the edge count and the level of B. The result is one of five control patterns.

The result appears as a one-cycle valid strobe together with a one-hot pattern code. A separate one-cycle hand-off strobe goes to the byte receiver when the pattern opens a data phase. After any report the detector returns to idle and waits for a fresh arming condition.

Top module: `twl_pattern_detector`

## Requirements
- R1: The detector arms only when synchronised line A is low and line B is high. A rise of A that is not preceded by such an arming condition produces no report.
- R2: While armed, every falling edge of B increments the edge count. The count is cleared whenever the detector is not armed.
- R3: When A rises with B high and a count of exactly 4, `pat_o` is 5'b00001 (start) and `data_go_o` pulses with `pat_valid_o`.
- R4: When A rises with B high and a count of exactly 6, `pat_o` is 5'b00010 (start with CRC) and `data_go_o` pulses with `pat_valid_o`.
- R5: When A rises with B high and a count of exactly 8, `pat_o` is 5'b00100 (occupancy) and `data_go_o` stays low.
- R6: When A rises with B high and a count of 14 or more, `pat_o` is 5'b01000 (bus reset) and `data_go_o` stays low. The counter saturates at 15, so any longer run is still classified as bus reset.
- R7: Any other count with B high, or B low when A rises, gives `pat_o` = 5'b10000 (frame error) and `data_go_o` stays low.
- R8: `pat_valid_o` is high for exactly one cycle per window. Exactly one bit of `pat_o` is set while it is high, and `pat_o` and `data_go_o` are zero otherwise. The report appears in the third clock cycle after the rising edge of A at the input pin.
- R9: Reset clears all outputs and the edge count. A window that re-arms after reset is classified only from edges seen after reset.
- R10: After a report the detector is idle. Pulses on B while A is high produce no report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the line activity |
| rst_n | input | 1 | Active-low synchronous reset |
| line_a_i | input | 1 | Asynchronous line A |
| line_b_i | input | 1 | Asynchronous line B |
| pat_valid_o | output | 1 | One-cycle strobe: a pattern has been classified |
| pat_o | output | 5 | One-hot pattern: bit0 start, bit1 start with CRC, bit2 occupancy, bit3 bus reset, bit4 frame error |
| data_go_o | output | 1 | One-cycle hand-off strobe to the byte receiver |

## Verification
The hardest state to reach from the ports is a count at or past saturation. Also hard is a window whose final B level differs from the level at which it was armed. The bench sweeps every edge count from 0 to 20, with B ending high and with B ending low. This drives the counter across its saturation point and through every classification boundary. A reset in the middle of a window shows that edges seen before reset do not leak into the next classification: the re-armed window reports a frame error instead of a start.

// File: rtl/twl_pkg.sv
package twl_pkg;
  localparam int unsigned CNT_W      = 4;
  localparam int unsigned PAT_N      = 5;
  localparam int unsigned CNT_START  = 4;
  localparam int unsigned CNT_CRC    = 6;
  localparam int unsigned CNT_OCC    = 8;
  localparam int unsigned CNT_RSTMIN = 14;

  localparam int unsigned IDX_START = 0;
  localparam int unsigned IDX_CRC   = 1;
  localparam int unsigned IDX_OCC   = 2;
  localparam int unsigned IDX_RST   = 3;
  localparam int unsigned IDX_FERR  = 4;

  typedef enum logic {ST_IDLE, ST_ARMED} det_state_e;

  // Map a closed window (edge count, final B level) onto a one-hot pattern.
  function automatic logic [PAT_N-1:0] classify(input logic [CNT_W-1:0] cnt,
                                                input logic b_high);
    logic [PAT_N-1:0] res;
    res = '0;
    if (!b_high)                         res[IDX_FERR]  = 1'b1;
    else if (cnt == CNT_W'(CNT_START))   res[IDX_START] = 1'b1;
    else if (cnt == CNT_W'(CNT_CRC))     res[IDX_CRC]   = 1'b1;
    else if (cnt == CNT_W'(CNT_OCC))     res[IDX_OCC]   = 1'b1;
    else if (cnt >= CNT_W'(CNT_RSTMIN))  res[IDX_RST]   = 1'b1;
    else                                 res[IDX_FERR]  = 1'b1;
    return res;
  endfunction

  // Patterns that hand the bus to the byte receiver.
  function automatic logic opens_data(input logic [PAT_N-1:0] pat);
    return pat[IDX_START] | pat[IDX_CRC];
  endfunction
endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/twl_edge_det.sv
module twl_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/twl_fall_counter.sv
module twl_fall_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i)   cnt_q <= '0;
    else if (inc_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc_i && !clear_i) |=> (cnt_q == CNT_MAX)); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/twl_classifier.sv
module twl_classifier
  import twl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_lvl_i,
  input  logic             a_rise_i,
  input  logic             b_lvl_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             armed_o,
  output logic             valid_o,
  output logic [PAT_N-1:0] pat_o,
  output logic             go_o
);
  det_state_e       state_q;
  logic [PAT_N-1:0] verdict;
  logic             window_end;
  logic             arm_cond;

  assign verdict    = classify(count_i, b_lvl_i);
  assign window_end = (state_q == ST_ARMED) && a_rise_i;
  assign arm_cond   = (state_q == ST_IDLE) && !a_lvl_i && b_lvl_i;
  assign armed_o    = (state_q == ST_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_o <= 1'b0;
      pat_o   <= '0;
      go_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      pat_o   <= '0;
      go_o    <= 1'b0;
      if (arm_cond) begin
        state_q <= ST_ARMED;
      end else if (window_end) begin
        state_q <= ST_IDLE;
        valid_o <= 1'b1;
        pat_o   <= verdict;
        go_o    <= opens_data(verdict);
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R8
  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($countones(pat_o) == 1)); // R8
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (pat_o == '0 && !go_o)); // R8
  AST_GO_START: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> (valid_o && (pat_o[IDX_START] || pat_o[IDX_CRC]))); // R3
  AST_NO_GO_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && pat_o[IDX_OCC]) |-> !go_o); // R5
  AST_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(state_q) == ST_ARMED && state_q == ST_IDLE)); // R1
  AST_ARM_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> (!$past(a_lvl_i) && $past(b_lvl_i))); // R1
endmodule

// File: rtl/twl_pattern_detector.sv
module twl_pattern_detector
  import twl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_a_i,
  input  logic             line_b_i,
  output logic             pat_valid_o,
  output logic [PAT_N-1:0] pat_o,
  output logic             data_go_o
);
  localparam int unsigned N_LINES = 2;
  localparam int unsigned SYNC_STAGES = 2;

  logic [N_LINES-1:0] lines_raw;
  logic [N_LINES-1:0] lines_s;
  logic [N_LINES-1:0] line_rise;
  logic [N_LINES-1:0] line_fall;
  logic [CNT_W-1:0]   fall_cnt;
  logic               armed;
  logic               cnt_inc;

  assign lines_raw = {line_b_i, line_a_i};

  twl_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lines_raw),
    .sync_o  (lines_s)
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_edge
    twl_edge_det u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lines_s[l]),
      .rise_o  (line_rise[l]),
      .fall_o  (line_fall[l])
    );
  end

  assign cnt_inc = armed & line_fall[1];

  twl_fall_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (~armed),
    .inc_i   (cnt_inc),
    .count_o (fall_cnt)
  );

  twl_classifier u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_lvl_i  (lines_s[0]),
    .a_rise_i (line_rise[0]),
    .b_lvl_i  (lines_s[1]),
    .count_i  (fall_cnt),
    .armed_o  (armed),
    .valid_o  (pat_valid_o),
    .pat_o    (pat_o),
    .go_o     (data_go_o)
  );

  AST_B_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && line_fall[1]) |=> (fall_cnt == '0)); // R2
  AST_HOLD_A_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lines_s[0]) && lines_s[0] && !armed) |=> !pat_valid_o); // R10
endmodule

// File: tb/twl_pattern_detector_tb_top.sv
module twl_pattern_detector_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_a = 1'b1;
  logic       line_b = 1'b1;
  logic       pat_valid;
  logic [4:0] pat;
  logic       data_go;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twl_pattern_detector dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_a_i    (line_a),
    .line_b_i    (line_b),
    .pat_valid_o (pat_valid),
    .pat_o       (pat),
    .data_go_o   (data_go)
  );

  function automatic logic [4:0] expect_pat(int edges, bit b_high);
    int sat;
    sat = (edges > 15) ? 15 : edges;
    if (!b_high)     return 5'd16;
    if (sat == 4)    return 5'd1;
    if (sat == 6)    return 5'd2;
    if (sat == 8)    return 5'd4;
    if (sat >= 14)   return 5'd8;
    return 5'd16;
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid/go/pat=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_b(int n);
    for (int i = 0; i < n; i++) begin
      line_b = 1'b0; cycles(3);
      line_b = 1'b1; cycles(3);
    end
  endtask

  // Watch for any report over n cycles; expect none.
  task automatic expect_silence(string req, int n);
    bit seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pat_valid || data_go || pat != 0) seen = 1;
    end
    check(req, {seen, 1'b0, 5'b0}, 7'b0);
  endtask

  task automatic run_window(int edges, bit b_high, string req);
    logic [4:0] ep;
    bit         eg;
    bit         early;
    ep = expect_pat(edges, b_high);
    eg = ep[0] | ep[1];
    line_a = 1'b1; line_b = 1'b1; cycles(4);
    line_a = 1'b0; cycles(4);
    early = 0;
    for (int i = 0; i < edges; i++) begin
      line_b = 1'b0; cycles(3);
      if (pat_valid) early = 1;
      line_b = 1'b1; cycles(3);
      if (pat_valid) early = 1;
    end
    if (!b_high) begin line_b = 1'b0; cycles(3); end
    line_a = 1'b1;
    cycles(2);
    check("R8 no early report", {early | pat_valid, 6'b0}, 7'b0);
    cycles(1);
    check(req, {pat_valid, data_go, pat}, {1'b1, eg, ep});
    cycles(1);
    check("R8 single cycle", {pat_valid, data_go, pat}, 7'b0);
    line_b = 1'b1; cycles(3);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cycles(3);
    check("R9 reset state", {pat_valid, data_go, pat}, 7'b0);
    rst_n = 1'b1;
    cycles(4);

    // R3..R7, R2, R6 saturation: sweep of counts and final B level.
    for (int e = 0; e <= 20; e++) begin
      for (int bh = 0; bh < 2; bh++) begin
        string tag;
        logic [4:0] ep;
        ep = expect_pat(e, bh[0]);
        tag = ep[0] ? "R3 start" : ep[1] ? "R4 start crc" : ep[2] ? "R5 occupancy" :
              ep[3] ? "R6 bus reset" : "R7 frame error";
        run_window(e, bh[0], $sformatf("%s R2 count=%0d bhigh=%0d", tag, e, bh));
      end
    end

    // R1: A low without B high never arms.
    line_a = 1'b1; line_b = 1'b0; cycles(4);
    line_a = 1'b0; cycles(6);
    line_a = 1'b1;
    expect_silence("R1 no arm with B low", 8);

    // R10: B pulses while A high are ignored.
    line_b = 1'b1; cycles(4);
    pulse_b(5);
    expect_silence("R10 idle B pulses", 6);

    // R9: reset mid-window discards earlier edges.
    line_a = 1'b0; cycles(4);
    pulse_b(4);
    rst_n = 1'b0; cycles(2);
    check("R9 outputs in reset", {pat_valid, data_go, pat}, 7'b0);
    rst_n = 1'b1; cycles(5);
    line_a = 1'b1; cycles(3);
    check("R9 count cleared by reset", {pat_valid, data_go, pat}, {1'b1, 1'b0, 5'd16});
    cycles(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule